// File: doc/BRIEF.md
# FM Read-Data Pulse Encoder

This block turns a stream of track bytes into the single-density frequency-modulated pulse train that a disk controller expects on its read-data line. Bytes arrive one at a time over a ready/valid handshake. Each byte comes with a flag that marks it as an address mark. The encoder sends each byte as sixteen equal cells that alternate between clock cells and data cells, starting with the most significant bit. A cell holding a one carries a short active pulse at its start. A cell holding a zero stays inactive for its whole length.

For ordinary bytes every clock cell holds a one. For flagged address-mark values the clock pattern has some ones removed, so that a receiver can find the mark in the bit stream. The encoder takes a new byte only in the final cell of the byte it is sending, so a steady supplier gets a gap-free stream. If no byte is offered in time, the line goes quiet and a sticky underrun flag records the event. The line is active-high in logic; a separate buffer inverts it for an open-collector bus. One parameter sets the number of system-clock ticks per microsecond.

Top module: `fm_pulse_encoder`

## Requirements
- R1: Each accepted byte is sent as 16 cells, each 4*TICKS_PER_US clock cycles long, in the order clock bit 7, data bit 7, clock bit 6, data bit 6, and so on down to data bit 0.
- R2: A cell holding a one drives rd_pulse_o high for its first TICKS_PER_US cycles and low for the rest of the cell; a cell holding a zero keeps rd_pulse_o low for the whole cell.
- R3: With trk_mark_i low, every clock cell holds a one and data cell n holds bit n of the byte, for any value 0x00 to 0xFF.
- R4: With trk_mark_i high and a byte value of 0xF8, 0xF9, 0xFA, 0xFB, 0xFD or 0xFE, the clock bits are 0xC7, taken from bit 7 down.
- R5: With trk_mark_i high and a byte value of 0xFC, the clock bits are 0xD7, taken from bit 7 down.
- R6: With trk_mark_i high and a byte value outside 0xF8 to 0xFE, the byte is sent as an ordinary byte, with all clock bits set to one.
- R7: trk_ready_o is high while the encoder is idle. While a byte is being sent, it is low except during the last cell, and only until one byte has been accepted in that cell.
- R8: A byte accepted during the last cell of the current byte starts exactly 16 cells after the start of the current byte, with no gap.
- R9: When the last cell of a byte ends and no next byte has been accepted, rd_pulse_o stays low, underrun_o goes high and stays high, and the encoder goes back to idle. A byte accepted after that starts a new stream.
- R10: A high underrun_clr_i clears underrun_o on the next clock edge, unless a new underrun happens in the same cycle.
- R11: After reset, rd_pulse_o and underrun_o are low and trk_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trk_byte_i | input | 8 | Track byte to encode |
| trk_mark_i | input | 1 | Marks trk_byte_i as an address mark |
| trk_valid_i | input | 1 | Byte and flag are valid |
| trk_ready_o | output | 1 | Encoder accepts a byte this cycle |
| rd_pulse_o | output | 1 | Registered FM pulse line, active-high |
| underrun_o | output | 1 | Sticky flag: the stream ran dry |
| underrun_clr_i | input | 1 | Clears underrun_o |

## Verification
The assertions assume that the supplier holds the byte and flag steady while trk_valid_i is high and trk_ready_o is low. They also assume that underrun_clr_i is raised only as a short pulse and never in the cycle where a frame ends. The bench drives the inputs only between clock edges and holds valid until it sees the handshake. It pulses the clear input only while the encoder is idle, long after any frame has ended. Bursts keep the next byte waiting before the final cell begins, so every gap-free case comes from a supplier that is really on time.

// File: rtl/fm_enc_pkg.sv
package fm_enc_pkg;

  localparam int unsigned CELLS_PER_BYTE = 16;
  localparam int unsigned CELL_IDX_W     = $clog2(CELLS_PER_BYTE);

  localparam logic [7:0] CLK_BITS_PLAIN = 8'hFF;
  localparam logic [7:0] CLK_BITS_MARK  = 8'hC7;
  localparam logic [7:0] CLK_BITS_INDEX = 8'hD7;

  typedef struct packed {
    logic [7:0] clk_bits;
    logic [7:0] dat_bits;
  } fm_frame_t;

  // Clock-cell pattern for one byte; only flagged F8..FE lose clock pulses.
  function automatic logic [7:0] clk_pattern(input logic [7:0] b, input logic is_mark);
    logic [7:0] p;
    p = CLK_BITS_PLAIN;
    if (is_mark) begin
      if (b == 8'hFC)
        p = CLK_BITS_INDEX;
      else if (b >= 8'hF8 && b <= 8'hFE)
        p = CLK_BITS_MARK;
    end
    return p;
  endfunction

endpackage

// File: rtl/fm_cell_timer.sv
module fm_cell_timer #(
  parameter int unsigned CELL_TICKS  = 16,
  parameter int unsigned PULSE_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic restart_i,
  output logic cell_end_o,
  output logic pulse_win_o
);

  localparam int unsigned TW = (CELL_TICKS > 1) ? $clog2(CELL_TICKS) : 1;
  localparam logic [TW-1:0] LAST_TICK  = TW'(CELL_TICKS - 1);
  localparam logic [TW-1:0] PULSE_LIM  = TW'(PULSE_TICKS);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
    end else if (restart_i || !run_i) begin
      tick_q <= '0;
    end else if (tick_q == LAST_TICK) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign cell_end_o  = run_i && (tick_q == LAST_TICK);
  assign pulse_win_o = (tick_q < PULSE_LIM);

  AST_TICK_IN_CELL: assert property (@(posedge clk) disable iff (rst)
    tick_q <= LAST_TICK); // R1

  AST_TICK_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> tick_q == '0); // R1

endmodule

// File: rtl/fm_frame_seq.sv
module fm_frame_seq
  import fm_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] trk_byte_i,
  input  logic       trk_mark_i,
  input  logic       trk_valid_i,
  output logic       trk_ready_o,
  input  logic       cell_end_i,
  output logic       restart_o,
  output logic       busy_o,
  output logic       cell_bit_o,
  output logic       underrun_o,
  input  logic       underrun_clr_i
);

  localparam logic [CELL_IDX_W-1:0] LAST_CELL = CELL_IDX_W'(CELLS_PER_BYTE - 1);

  logic                  busy_q;
  logic [CELL_IDX_W-1:0] cell_q;
  logic [7:0]            clk_sh_q, dat_sh_q;
  fm_frame_t             pend_q;
  logic                  pend_v_q;
  logic                  underrun_q;

  logic      last_cell, fire, have_next, frame_end, load, dry;
  fm_frame_t in_frame, nxt_frame;

  assign last_cell   = busy_q && (cell_q == LAST_CELL);
  assign trk_ready_o = !pend_v_q && (!busy_q || last_cell);
  assign fire        = trk_valid_i && trk_ready_o;
  assign have_next   = pend_v_q || fire;
  assign frame_end   = last_cell && cell_end_i;
  assign load        = have_next && (!busy_q || frame_end);
  assign dry         = frame_end && !have_next;

  always_comb begin
    in_frame.clk_bits = clk_pattern(trk_byte_i, trk_mark_i);
    in_frame.dat_bits = trk_byte_i;
    nxt_frame         = pend_v_q ? pend_q : in_frame;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cell_q   <= '0;
      clk_sh_q <= '0;
      dat_sh_q <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (load) begin
      busy_q   <= 1'b1;
      cell_q   <= '0;
      clk_sh_q <= nxt_frame.clk_bits;
      dat_sh_q <= nxt_frame.dat_bits;
      pend_v_q <= 1'b0;
    end else begin
      if (fire) begin
        pend_q   <= in_frame;
        pend_v_q <= 1'b1;
      end
      if (frame_end) begin
        busy_q <= 1'b0;
        cell_q <= '0;
      end else if (busy_q && cell_end_i) begin
        cell_q <= cell_q + 1'b1;
        if (cell_q[0]) begin
          clk_sh_q <= {clk_sh_q[6:0], 1'b0};
          dat_sh_q <= {dat_sh_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      underrun_q <= 1'b0;
    else if (dry)
      underrun_q <= 1'b1;
    else if (underrun_clr_i)
      underrun_q <= 1'b0;
  end

  assign restart_o  = load;
  assign busy_o     = busy_q;
  assign cell_bit_o = cell_q[0] ? dat_sh_q[7] : clk_sh_q[7];
  assign underrun_o = underrun_q;

  AST_READY_LAST_CELL: assert property (@(posedge clk) disable iff (rst)
    busy_q && (cell_q != LAST_CELL) |-> !trk_ready_o); // R7

  AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
    pend_v_q |-> !trk_ready_o); // R7

  AST_GAPLESS_RELOAD: assert property (@(posedge clk) disable iff (rst)
    frame_end && have_next |=> busy_q && (cell_q == '0)); // R8

  AST_DRY_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    dry |=> !busy_q && underrun_q); // R9

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    underrun_q && !underrun_clr_i |=> underrun_q); // R9

  AST_UNDERRUN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    underrun_clr_i && !dry |=> !underrun_q); // R10

endmodule

// File: rtl/fm_pulse_encoder.sv
module fm_pulse_encoder #(
  parameter int unsigned TICKS_PER_US = 4,
  parameter int unsigned CELL_US      = 4,
  parameter int unsigned PULSE_US     = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] trk_byte_i,
  input  logic       trk_mark_i,
  input  logic       trk_valid_i,
  output logic       trk_ready_o,
  output logic       rd_pulse_o,
  output logic       underrun_o,
  input  logic       underrun_clr_i
);

  localparam int unsigned CELL_TICKS  = TICKS_PER_US * CELL_US;
  localparam int unsigned PULSE_TICKS = TICKS_PER_US * PULSE_US;

  logic cell_end, pulse_win, restart, busy, cell_bit;
  logic pulse_q;

  fm_cell_timer #(
    .CELL_TICKS (CELL_TICKS),
    .PULSE_TICKS(PULSE_TICKS)
  ) timer_i (
    .clk        (clk),
    .rst        (rst),
    .run_i      (busy),
    .restart_i  (restart),
    .cell_end_o (cell_end),
    .pulse_win_o(pulse_win)
  );

  fm_frame_seq seq_i (
    .clk           (clk),
    .rst           (rst),
    .trk_byte_i    (trk_byte_i),
    .trk_mark_i    (trk_mark_i),
    .trk_valid_i   (trk_valid_i),
    .trk_ready_o   (trk_ready_o),
    .cell_end_i    (cell_end),
    .restart_o     (restart),
    .busy_o        (busy),
    .cell_bit_o    (cell_bit),
    .underrun_o    (underrun_o),
    .underrun_clr_i(underrun_clr_i)
  );

  always_ff @(posedge clk) begin
    if (rst)
      pulse_q <= 1'b0;
    else
      pulse_q <= busy && cell_bit && pulse_win;
  end

  assign rd_pulse_o = pulse_q;

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy && $past(!busy) |-> !rd_pulse_o); // R9

  AST_PULSE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    rd_pulse_o |-> $past(pulse_win)); // R2

endmodule

// File: tb/fm_pulse_encoder_tb_top.sv
module fm_pulse_encoder_tb_top;

  localparam int TPU   = 4;
  localparam int CELLT = 4 * TPU;
  localparam int PULT  = TPU;
  localparam int FRAME = 16 * CELLT;

  typedef struct {
    logic [7:0] clk_bits;
    logic [7:0] dat_bits;
    bit         gapless;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] trk_byte = '0;
  logic trk_mark = 1'b0, trk_valid = 1'b0, clr = 1'b0;
  logic trk_ready, rd_pulse, underrun;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fm_pulse_encoder #(.TICKS_PER_US(TPU)) dut_i (
    .clk(clk), .rst(rst),
    .trk_byte_i(trk_byte), .trk_mark_i(trk_mark), .trk_valid_i(trk_valid),
    .trk_ready_o(trk_ready), .rd_pulse_o(rd_pulse),
    .underrun_o(underrun), .underrun_clr_i(clr)
  );

  function automatic logic [7:0] exp_clk(input logic [7:0] b, input logic m);
    if (m && b == 8'hFC) return 8'hD7;                 // R5
    if (m && b >= 8'hF8 && b <= 8'hFE) return 8'hC7;  // R4
    return 8'hFF;                                      // R3, R6
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: caller is at a negedge; pushes the expectation, holds valid until accepted.
  task automatic send(input logic [7:0] b, input logic m, input bit gap, input string tag);
    exp_t e;
    e.clk_bits = exp_clk(b, m);
    e.dat_bits = b;
    e.gapless  = gap;
    e.tag      = tag;
    sb.push_back(e);
    trk_byte  = b;
    trk_mark  = m;
    trk_valid = 1'b1;
    while (!trk_ready) @(negedge clk);
    @(negedge clk);
    trk_valid = 1'b0;
  endtask

  // Monitor: decodes each byte's 16 cells and compares against the scoreboard.
  initial begin : monitor
    int prev_start;
    prev_start = -1;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      int start;
      exp_t e;
      while (!rd_pulse) @(negedge clk);
      start = cyc;
      if (sb.size() == 0) begin
        chk(0, "R9 spurious pulse", 1, 0);
        @(negedge clk);
        continue;
      end
      e = sb.pop_front();
      if (e.gapless)
        chk(start - prev_start == FRAME, "R8 gapless start", start - prev_start, FRAME);
      prev_start = start;
      for (int k = 0; k < 16; k++) begin
        bit cb, bad;
        int badv;
        cb = (k % 2 == 0) ? e.clk_bits[7 - k/2] : e.dat_bits[7 - k/2];
        bad = 0;
        badv = 0;
        for (int j = 0; j < CELLT; j++) begin
          logic want;
          want = cb && (j < PULT);
          if (rd_pulse !== want && !bad) begin
            bad = 1;
            badv = {k, j};
          end
          if (k == 8 && j == 2)
            chk(trk_ready == 1'b0, "R7 ready low mid-byte", trk_ready, 0);
          @(negedge clk);
        end
        chk(!bad, {"R1 R2 ", e.tag}, badv, {k, 8'h00});
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(rd_pulse == 1'b0, "R11 line low", rd_pulse, 0);
    chk(underrun == 1'b0, "R11 underrun low", underrun, 0);
    chk(trk_ready == 1'b1, "R11 ready high", trk_ready, 1);

    // R3: single ordinary byte, then R9 underrun
    send(8'hA5, 1'b0, 0, "R3 A5");
    repeat (FRAME + 10) @(negedge clk);
    chk(underrun == 1'b1, "R9 underrun set", underrun, 1);
    chk(trk_ready == 1'b1, "R7 ready idle", trk_ready, 1);
    repeat (40) @(negedge clk);
    chk(underrun == 1'b1, "R9 underrun held", underrun, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(underrun == 1'b0, "R10 underrun cleared", underrun, 0);

    // Burst: ordinary bytes and every mark (R3 R4 R5 R6 R8)
    send(8'h00, 1'b0, 0, "R3 00");
    send(8'hFF, 1'b0, 1, "R3 FF");
    send(8'hFE, 1'b1, 1, "R4 FE");
    chk(underrun == 1'b0, "R8 no underrun in burst", underrun, 0);
    send(8'hFB, 1'b1, 1, "R4 FB");
    send(8'hF8, 1'b1, 1, "R4 F8");
    send(8'hF9, 1'b1, 1, "R4 F9");
    send(8'hFA, 1'b1, 1, "R4 FA");
    send(8'hFD, 1'b1, 1, "R4 FD");
    send(8'hFC, 1'b1, 1, "R5 FC");
    send(8'h55, 1'b1, 1, "R6 55");
    send(8'hF7, 1'b1, 1, "R6 F7");
    send(8'hFC, 1'b0, 1, "R3 FC plain");
    send(8'h3C, 1'b0, 1, "R3 3C");
    chk(underrun == 1'b0, "R8 no underrun late burst", underrun, 0);
    repeat (FRAME + 20) @(negedge clk);
    chk(underrun == 1'b1, "R9 underrun after burst", underrun, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;

    // R9: restart after underrun, a late byte, then a short pair
    repeat (37) @(negedge clk);
    send(8'h81, 1'b0, 0, "R9 restart 81");
    repeat (FRAME + 5) @(negedge clk);
    send(8'hFE, 1'b1, 0, "R4 FE late");
    send(8'h01, 1'b0, 1, "R8 01");
    repeat (FRAME * 2 + 20) @(negedge clk);
    chk(sb.size() == 0, "R1 all bytes seen", sb.size(), 0);
    chk(rd_pulse == 1'b0, "R9 line quiet", rd_pulse, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule